// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a bus-mapped timer built around a counter of up to 32 bits. The counter is advanced by a programmable divider, and the divider is fed by one of several tick enables chosen through the control register. Each tick enable is a single-cycle pulse that is already synchronous to the bus clock. One compare channel watches the counter. When the counter reaches the compare value, the channel raises a sticky status flag. That flag drives an interrupt line through a mask bit in the control register.

Software reads and writes the registers over a single-cycle register bus. Read data is combinational from the address. Writes take effect at the clock edge where select and write are both high.

Two counting styles are available. In free-running mode the counter passes through a match and wraps naturally. In restart mode it returns to zero after a match. A software reset, triggered from the control register, puts every register back to its default. It reports busy for a fixed number of cycles, then clears itself.

Top module: `cmp_timer`

## Requirements
- R1: After reset the registers read as follows: control 0, divider 0, compare 0xFFFFFFFF, capture 0, counter 0, status 0. The interrupt is low. Byte offsets are: control 0x00, divider 0x04, compare 0x08, capture 0x0C, counter 0x10, status 0x14.
- R2: Control bit 0 is the run enable. Control bits 3:1 choose the tick source: 1 selects `tick_fast`, 3 selects `tick_ext`, 4 selects `tick_slow`, and every other code selects nothing. The counter moves only when the enable is 1 and the chosen source pulses.
- R3: With divider value D, the counter advances once for every D+1 pulses of the chosen source.
- R4: Any write to the divider register restarts the internal divide count from zero.
- R5: When control bit 8 is 1 (free-running), the counter keeps incrementing through a compare match.
- R6: When control bit 8 is 0 (restart), the counter returns to 0 on the next advance after it equals the compare value.
- R7: Status bit 0 becomes 1 on the same clock edge at which the counter takes the compare value.
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: If a match and a clearing write happen on the same edge, the status flag ends up 1.
- R10: `irq` is high exactly when control bit 4 and status bit 0 are both 1.
- R11: Writing 1 to control bit 15 restores all registers, the counter and the divider to their defaults. Bit 15 then reads 1 for exactly 4 cycles and reads 0 afterwards.
- R12: Register writes made while the software reset is busy have no effect.
- R13: The capture register always reads 0. Writes to the counter and capture offsets do not change the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick_fast | input | 1 | Fast clock tick enable |
| tick_ext | input | 1 | External clock tick enable |
| tick_slow | input | 1 | Slow (32 kHz) clock tick enable |
| irq | output | 1 | Compare interrupt |

## Verification
The assertions are evaluated on every cycle and cover the following:
- The counter holds whenever no divided step occurs.
- The counter increments by exactly one per step in free-running mode, including across the wrap.
- The counter reloads to zero after a match in restart mode.
- The status flag never rises without a step.
- The divide count never exceeds the divider value.
- The busy countdown only decrements, and it keeps every register at its default while it is nonzero.

Some behaviour is visible only in the bench scenarios:
- Which source code selects which tick input.
- The exact divide ratio and the divider restart after a write.
- The priority between setting and clearing the status flag.
- The interrupt gating.
- The precise four-cycle busy readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register byte offsets
   localparam int unsigned OFS_CTRL = 'h00;
   localparam int unsigned OFS_PSC  = 'h04;
   localparam int unsigned OFS_CMP  = 'h08;
   localparam int unsigned OFS_CAP  = 'h0C;
   localparam int unsigned OFS_CNT  = 'h10;
   localparam int unsigned OFS_STAT = 'h14;

   // control bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_SRC  = 1;
   localparam int unsigned CB_CIE  = 4;
   localparam int unsigned CB_FREE = 8;
   localparam int unsigned CB_SRST = 15;

   // tick source codes
   localparam logic [2:0] SRC_OFF  = 3'd0;
   localparam logic [2:0] SRC_FAST = 3'd1;
   localparam logic [2:0] SRC_EXT  = 3'd3;
   localparam logic [2:0] SRC_SLOW = 3'd4;

   typedef struct packed {
      logic       free;
      logic       cie;
      logic [2:0] src;
      logic       en;
   } ctrl_t;

   localparam ctrl_t CTRL_DEFAULT = '{free: 1'b0, cie: 1'b0, src: SRC_OFF, en: 1'b0};

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PSC_W    = 12,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned SRST_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output ctrl_t             ctrl,
   output logic [PSC_W-1:0]  psc,
   output logic [CNT_W-1:0]  cmp,
   output logic              psc_wr,
   output logic              stat_clr,
   output logic              srst,
   output logic              busy
);

   localparam int unsigned BUSY_W = $clog2(SRST_CYC + 1);

   generate
      if (SRST_CYC < 1) begin : g_bad_srst
         $error("SRST_CYC must be at least 1");
      end
      if (PSC_W > DATA_W) begin : g_bad_psc
         $error("PSC_W must not exceed DATA_W");
      end
   endgenerate

   logic [BUSY_W-1:0] busy_cnt;
   logic              wr_ok;
   logic              hit_ctrl, hit_psc, hit_cmp, hit_stat;

   assign busy     = (busy_cnt != '0);
   assign wr_ok    = bus_sel && bus_wr && !busy;
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_psc  = (bus_addr == ADDR_W'(OFS_PSC));
   assign hit_cmp  = (bus_addr == ADDR_W'(OFS_CMP));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));

   assign srst     = wr_ok && hit_ctrl && bus_wdata[CB_SRST];
   assign psc_wr   = wr_ok && hit_psc;
   assign stat_clr = wr_ok && hit_stat && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= CTRL_DEFAULT;
         psc      <= '0;
         cmp      <= '1;
         busy_cnt <= '0;
      end else if (srst) begin
         ctrl     <= CTRL_DEFAULT;
         psc      <= '0;
         cmp      <= '1;
         busy_cnt <= BUSY_W'(SRST_CYC);
      end else begin
         if (busy) begin
            busy_cnt <= busy_cnt - BUSY_W'(1);
         end
         if (wr_ok && hit_ctrl) begin
            ctrl <= '{free: bus_wdata[CB_FREE],
                      cie:  bus_wdata[CB_CIE],
                      src:  bus_wdata[CB_SRC +: 3],
                      en:   bus_wdata[CB_EN]};
         end
         if (psc_wr) begin
            psc <= bus_wdata[PSC_W-1:0];
         end
         if (wr_ok && hit_cmp) begin
            cmp <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   // R11: the busy countdown never exceeds its start value and only steps down
   p_busy_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= BUSY_W'(SRST_CYC));
   p_busy_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !srst) |=> (busy_cnt == $past(busy_cnt) - BUSY_W'(1)));
   // R12: while busy, every register stays at its default
   p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ctrl == CTRL_DEFAULT && psc == '0 && cmp == '1));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int unsigned PSC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [2:0]       src,
   input  logic             tick_fast,
   input  logic             tick_ext,
   input  logic             tick_slow,
   input  logic [PSC_W-1:0] psc,
   output logic             step
);

   generate
      if (PSC_W < 1) begin : g_bad_w
         $error("PSC_W must be at least 1");
      end
   endgenerate

   logic [PSC_W-1:0] pcnt;
   logic             src_tick;
   logic             pre_tick;

   always_comb begin
      case (src)
         SRC_FAST: src_tick = tick_fast;
         SRC_EXT:  src_tick = tick_ext;
         SRC_SLOW: src_tick = tick_slow;
         default:  src_tick = 1'b0;
      endcase
   end

   assign pre_tick = en && src_tick;
   assign step     = pre_tick && (pcnt == psc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (clr) begin
         pcnt <= '0;
      end else if (pre_tick) begin
         pcnt <= step ? '0 : pcnt + PSC_W'(1);
      end
   end

   // R3: the divide count stays within the programmed ratio
   p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= psc);
   // R2: no source pulse, no step
   p_no_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pre_tick |-> !step);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             free,
   input  logic [CNT_W-1:0] cmp,
   input  logic             stat_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             stat
);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] nxt;
   logic             at_cmp;
   logic             hit;

   assign at_cmp = (cnt == cmp);
   assign nxt    = (!free && at_cmp) ? '0 : cnt + CNT_W'(1);
   assign hit    = step && (nxt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= nxt;
      end
   end

   // set has priority over the write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= 1'b0;
      end else if (clr) begin
         stat <= 1'b0;
      end else if (hit) begin
         stat <= 1'b1;
      end else if (stat_clr) begin
         stat <= 1'b0;
      end
   end

   // R5: free-running steps add exactly one, wrapping at the top
   p_free_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && free && !clr) |=> (cnt == $past(cnt) + CNT_W'(1)));
   // R6: restart mode reloads zero after a match
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !free && !clr && cnt == cmp) |=> (cnt == '0));
   // R3: the counter holds between steps
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(cnt));
   // R7: the flag can only rise together with a counter step
   p_stat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> !$rose(stat));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PSC_W    = 12,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned SRST_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_fast,
   input  logic              tick_ext,
   input  logic              tick_slow,
   output logic              irq
);

   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold the control register");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must not exceed DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach the status offset");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [PSC_W-1:0]  psc;
   logic [CNT_W-1:0]  cmp;
   logic [CNT_W-1:0]  cnt;
   logic              psc_wr, stat_clr, srst, busy;
   logic              step, stat;
   logic [DATA_W-1:0] ctrl_rd;

   tmr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W),
      .CNT_W(CNT_W), .SRST_CYC(SRST_CYC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .ctrl(ctrl), .psc(psc), .cmp(cmp),
      .psc_wr(psc_wr), .stat_clr(stat_clr),
      .srst(srst), .busy(busy)
   );

   tmr_prescale #(.PSC_W(PSC_W)) u_pre (
      .clk(clk), .rst_n(rst_n),
      .clr(srst || psc_wr),
      .en(ctrl.en), .src(ctrl.src),
      .tick_fast(tick_fast), .tick_ext(tick_ext), .tick_slow(tick_slow),
      .psc(psc), .step(step)
   );

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(srst), .step(step), .free(ctrl.free),
      .cmp(cmp), .stat_clr(stat_clr),
      .cnt(cnt), .stat(stat)
   );

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[CB_EN]       = ctrl.en;
      ctrl_rd[CB_SRC +: 3] = ctrl.src;
      ctrl_rd[CB_CIE]      = ctrl.cie;
      ctrl_rd[CB_FREE]     = ctrl.free;
      ctrl_rd[CB_SRST]     = busy;
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_CTRL): bus_rdata = ctrl_rd;
         ADDR_W'(OFS_PSC):  bus_rdata = DATA_W'(psc);
         ADDR_W'(OFS_CMP):  bus_rdata = DATA_W'(cmp);
         ADDR_W'(OFS_CAP):  bus_rdata = '0;
         ADDR_W'(OFS_CNT):  bus_rdata = DATA_W'(cnt);
         ADDR_W'(OFS_STAT): bus_rdata = DATA_W'(stat);
         default:           bus_rdata = '0;
      endcase
   end

   assign irq = ctrl.cie && stat;

endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_fast = 1'b0;
   logic        tick_ext = 1'b0;
   logic        tick_slow = 1'b0;
   logic        irq;

   always #4 clk = ~clk;

   cmp_timer dut (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_fast(tick_fast), .tick_ext(tick_ext), .tick_slow(tick_slow),
      .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    total = 0;
   int    bad = 0;
   bit    finished = 0;

   localparam logic [4:0] A_CTRL = 5'h00, A_PSC = 5'h04, A_CMP = 5'h08,
                          A_CAP = 5'h0C, A_CNT = 5'h10, A_STAT = 5'h14;

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
      ->chk_ev;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      #1;
      q.push_back('{is_irq: 1'b1, exp: {31'b0, e}, tag: tag});
      ->chk_ev;
      @(negedge clk);
   endtask

   task automatic ticks(input int which, input int n);
      if (which == 0) tick_fast = 1'b1;
      else if (which == 1) tick_ext = 1'b1;
      else tick_slow = 1'b1;
      repeat (n) @(negedge clk);
      tick_fast = 1'b0; tick_ext = 1'b0; tick_slow = 1'b0;
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, 32'h0, "R1 ctrl");
      rd(A_PSC,  32'h0, "R1 psc");
      rd(A_CMP,  32'hFFFF_FFFF, "R1 cmp");
      rd(A_CAP,  32'h0, "R1 cap");
      rd(A_CNT,  32'h0, "R1 cnt");
      rd(A_STAT, 32'h0, "R1 stat");
      chk_irq(1'b0, "R1 irq");

      // R2 fast source
      wr(A_CTRL, 32'h3);
      ticks(0, 10);
      rd(A_CNT, 32'd10, "R2 fast source");
      // R13 counter and capture are read-only
      wr(A_CNT, 32'h1234);
      wr(A_CAP, 32'h55);
      rd(A_CNT, 32'd10, "R13 cnt write ignored");
      rd(A_CAP, 32'h0, "R13 cap reads zero");

      // R2 source codes and enable
      wr(A_CTRL, 32'h1);
      ticks(0, 5);
      rd(A_CNT, 32'd10, "R2 no source");
      wr(A_CTRL, 32'h7);
      ticks(0, 4);
      rd(A_CNT, 32'd10, "R2 ext ignores fast");
      ticks(1, 6);
      rd(A_CNT, 32'd16, "R2 ext source");
      wr(A_CTRL, 32'h9);
      ticks(2, 3);
      rd(A_CNT, 32'd19, "R2 slow source");
      wr(A_CTRL, 32'h2);
      ticks(0, 4);
      rd(A_CNT, 32'd19, "R2 disabled");

      // R3 divide by three, R4 divider restart
      wr(A_PSC, 32'd2);
      wr(A_CTRL, 32'h3);
      ticks(0, 7);
      rd(A_CNT, 32'd21, "R3 divide by 3");
      wr(A_PSC, 32'd2);
      ticks(0, 2);
      rd(A_CNT, 32'd21, "R4 divider restarted");
      ticks(0, 1);
      rd(A_CNT, 32'd22, "R4 third pulse steps");
      rd(A_PSC, 32'd2, "R3 psc readback");

      // R11 soft reset, R12 writes ignored while busy
      wr(A_CMP, 32'h55);
      wr(A_CTRL, 32'h8000);
      rd(A_CTRL, 32'h8000, "R11 busy cycle 1");
      wr(A_PSC, 32'd7);
      rd(A_CTRL, 32'h8000, "R11 busy cycle 3");
      rd(A_CTRL, 32'h8000, "R11 busy cycle 4");
      rd(A_CTRL, 32'h0, "R11 self cleared");
      rd(A_PSC, 32'h0, "R12 write ignored");
      rd(A_CMP, 32'hFFFF_FFFF, "R11 cmp default");
      rd(A_CNT, 32'h0, "R11 cnt cleared");

      // R5 free-running through a match, R7 flag, R8, R10
      wr(A_CMP, 32'd5);
      wr(A_CTRL, 32'h113);
      ticks(0, 4);
      rd(A_STAT, 32'h0, "R7 no flag before match");
      chk_irq(1'b0, "R10 irq low before match");
      ticks(0, 1);
      rd(A_CNT, 32'd5, "R7 at match");
      rd(A_STAT, 32'h1, "R7 flag set");
      chk_irq(1'b1, "R10 irq high");
      ticks(0, 3);
      rd(A_CNT, 32'd8, "R5 passes match");
      wr(A_STAT, 32'h0);
      rd(A_STAT, 32'h1, "R8 write 0 no effect");
      wr(A_CTRL, 32'h103);
      chk_irq(1'b0, "R10 masked");
      rd(A_STAT, 32'h1, "R10 flag kept while masked");
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'h0, "R8 write 1 clears");

      // R6 restart mode
      wr(A_CTRL, 32'h8000);
      repeat (5) @(negedge clk);
      wr(A_CMP, 32'd3);
      wr(A_CTRL, 32'h13);
      ticks(0, 3);
      rd(A_CNT, 32'd3, "R6 reached compare");
      rd(A_STAT, 32'h1, "R7 restart flag");
      ticks(0, 1);
      rd(A_CNT, 32'd0, "R6 reload to zero");
      ticks(0, 2);
      rd(A_CNT, 32'd2, "R6 counts again");

      // R9 set beats clear on the same edge
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'h0, "R8 cleared before collision");
      tick_fast = 1'b1;
      wr(A_STAT, 32'h1);
      tick_fast = 1'b0;
      rd(A_CNT, 32'd3, "R9 counter matched");
      rd(A_STAT, 32'h1, "R9 set wins");
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'h0, "R8 clear afterwards");

      #1;
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule